// File: doc/BRIEF.md
# Word FIFO Status and Interrupt Unit

This block sits between a register bus and a serial flash engine. It holds a transmit word FIFO and a receive word FIFO. Software pushes 32-bit words into the transmit side through a data register, and the engine drains them one byte at a time, least significant byte first. Bytes that the engine receives are packed four to a word into the receive side, and software pops them through the same data register. The unit reports FIFO state through a status word. It gathers eight interrupt sources into sticky raw bits, which software can mask and clear. A self-clearing soft reset empties both FIFOs and holds the engine in reset while it runs.

Registers are selected by a 3-bit word index. The map is: 0 mask, 1 clear, 2 thresholds, 3 recovery, 4 masked status, 5 FIFO status, 6 raw status, 7 data. Reads are combinational. Register writes and FIFO pops take effect at the clock edge on which the strobe is high. Each interrupt source is set on the edge after its condition holds, and the set takes priority over a clear in the same cycle.

Top module: `fifo_irq_unit`

## Requirements
- R1: The mask register (index 0, bits [7:0]) resets to all ones. A 1 in a mask bit hides that source. The masked status register (index 4) reads raw AND NOT mask.
- R2: The raw status register (index 6) records every event whether or not the source is masked.
- R3: Writing the clear register (index 1) clears each raw bit whose write-data bit is 1. Writing 0xFF clears them all. A source that is active in the same cycle stays set.
- R4: irq_o is the OR of the masked status bits, registered, so it follows the masked status with one cycle of delay.
- R5: FIFO status (index 5) has the following fields. Bit 0 is transmit full, bit 1 transmit empty, bit 2 receive empty and bit 3 receive full. Bits [13:8] give the free transmit words and bits [20:16] the occupied receive words. All other bits read zero.
- R6: Each word written to the data register (index 7) leaves on tx_byte_o as four bytes, byte [7:0] first. One byte is delivered per cycle in which tx_valid_o and tx_ready_i are both high.
- R7: Received bytes are packed least significant first into words that software pops by reading index 7. rx_ready_o drops when the fourth byte of a word would find the receive FIFO full.
- R8: A data write into a full transmit FIFO is discarded and sets raw bit 2 (transmit overflow).
- R9: A data read from an empty receive FIFO returns zero and sets raw bit 1 (receive underflow).
- R10: The threshold register (index 2) holds the transmit threshold in bits [4:0] and the receive threshold in bits [12:8]. Raw bit 0 sets while the receive word count exceeds the receive threshold. Raw bit 3 sets while the transmit word count is at or below the transmit threshold.
- R11: Writing 1 to bit 0 of the recovery register (index 3) starts a soft reset that lasts RST_CYCLES cycles. While it runs the bit reads 1 and eng_flush_o is high. It empties both FIFOs and then clears itself.
- R12: The engine event inputs done_i, bus_err_i, proto_err_i and dma_done_i set raw bits 4, 5, 6 and 7 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on data read) |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| tx_valid_o | output | 1 | Transmit byte available to engine |
| tx_byte_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Engine takes transmit byte |
| rx_valid_i | input | 1 | Engine offers a received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Unit accepts received byte |
| done_i | input | 1 | Transfer finished event |
| bus_err_i | input | 1 | Bus error event |
| proto_err_i | input | 1 | Serial protocol error event |
| dma_done_i | input | 1 | DMA done event |
| eng_flush_o | output | 1 | Engine reset during soft reset |
| irq_o | output | 1 | Interrupt request |

## Verification
The FIFO paths are tested with distinct byte patterns in both directions, so that a swapped byte lane or a missed pop changes the words seen. Each path is also driven to its capacity limit. A seventeenth write shows that the data is dropped, not wrapped, because exactly sixty-four bytes drain afterwards. A blocked fourth receive byte shows the backpressure. Single event pulses with all sources masked, and then with one source unmasked, separate the raw view, the masked view and the one-cycle-late interrupt. Threshold values of one and two move the level-driven sources away from their reset behaviour.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int NUM_SRC = 8;

  typedef enum logic [2:0] {
    SEL_MASK    = 3'd0,
    SEL_CLEAR   = 3'd1,
    SEL_THRESH  = 3'd2,
    SEL_RECOVER = 3'd3,
    SEL_MSTAT   = 3'd4,
    SEL_FSTAT   = 3'd5,
    SEL_RSTAT   = 3'd6,
    SEL_DATA    = 3'd7
  } reg_sel_e;

  // interrupt source bit positions
  localparam int SRC_RX_FULL  = 0;
  localparam int SRC_RX_UNDER = 1;
  localparam int SRC_TX_OVER  = 2;
  localparam int SRC_TX_EMPTY = 3;
  localparam int SRC_DONE     = 4;
  localparam int SRC_BUS_ERR  = 5;
  localparam int SRC_PROTO    = 6;
  localparam int SRC_DMA      = 7;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_full_push_dropped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (count_o == $past(count_o)));
  assert_count_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o <= CNT_W'(DEPTH)));
endmodule

// File: rtl/tx_unpack.sv
module tx_unpack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        avail_i,
  input  logic [31:0] word_i,
  input  logic        ready_i,
  output logic        valid_o,
  output logic [7:0]  byte_o,
  output logic        pop_o
);
  logic [1:0] idx_q;

  assign valid_o = avail_i && !flush_i;
  assign byte_o  = word_i[idx_q*8 +: 8];
  assign pop_o   = valid_o && ready_i && (idx_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (flush_i)           idx_q <= '0;
    else if (valid_o && ready_i) idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/rx_pack.sv
module rx_pack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        room_i,
  input  logic        valid_i,
  input  logic [7:0]  byte_i,
  output logic        ready_o,
  output logic        push_o,
  output logic [31:0] word_o
);
  logic [1:0]  idx_q;
  logic [23:0] acc_q;
  logic        take;

  assign ready_o = !flush_i && ((idx_q != 2'd3) || room_i);
  assign take    = valid_i && ready_o;
  assign push_o  = take && (idx_q == 2'd3);
  assign word_o  = {byte_i, acc_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (flush_i) begin
      idx_q <= '0;
    end else if (take) begin
      idx_q <= idx_q + 1'b1;
      case (idx_q)
        2'd0:    acc_q[7:0]   <= byte_i;
        2'd1:    acc_q[15:8]  <= byte_i;
        2'd2:    acc_q[23:16] <= byte_i;
        default: acc_q        <= acc_q;
      endcase
    end
  end

  assert_no_push_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> room_i);
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] masked_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q, mask_q, clr_eff;
  logic         irq_q;

  assign clr_eff  = clr_we_i ? clr_i : '0;
  assign masked_o = raw_q & ~mask_q;
  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr_eff) | set_i;
      if (mask_we_i) mask_q <= mask_i;
      irq_q <= |masked_o;
    end
  end

  assert_irq_lag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|masked_o));
  assert_clear_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((clr_i & ~set_i) != '0)) |=> ((raw_o & $past(clr_i & ~set_i)) == '0));
  assert_event_recorded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fsi_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [2:0]  reg_idx_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_byte_o,
  input  logic        tx_ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  output logic        rx_ready_o,
  input  logic        done_i,
  input  logic        bus_err_i,
  input  logic        proto_err_i,
  input  logic        dma_done_i,
  output logic        eng_flush_o,
  output logic        irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int RC_W  = $clog2(RST_CYCLES + 1);

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_idx_i);

  logic [4:0] tx_thr_q, rx_thr_q;
  logic busy_q;
  logic [RC_W-1:0] rc_cnt_q;

  logic [31:0] tx_word, rx_word, rx_in_word;
  logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_free;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_pop, rx_push;
  logic data_wr, data_rd, tx_push, tx_ovf, rx_pop, rx_unf;
  logic [NUM_SRC-1:0] ev_set, raw, mask, masked;

  assign data_wr = reg_we_i && (sel == SEL_DATA);
  assign data_rd = reg_re_i && (sel == SEL_DATA);
  assign tx_push = data_wr && !tx_full;
  assign tx_ovf  = data_wr && tx_full;
  assign rx_pop  = data_rd && !rx_empty;
  assign rx_unf  = data_rd && rx_empty;
  assign tx_free = CNT_W'(DEPTH) - tx_cnt;
  assign eng_flush_o = busy_q;

  word_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(busy_q), .push_i(tx_push), .wdata_i(reg_wdata_i),
    .pop_i(tx_pop), .rdata_o(tx_word), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty));

  word_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(busy_q), .push_i(rx_push), .wdata_i(rx_in_word),
    .pop_i(rx_pop), .rdata_o(rx_word), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty));

  tx_unpack u_tx_unpack (
    .clk_i, .rst_ni, .flush_i(busy_q), .avail_i(!tx_empty), .word_i(tx_word),
    .ready_i(tx_ready_i), .valid_o(tx_valid_o), .byte_o(tx_byte_o), .pop_o(tx_pop));

  rx_pack u_rx_pack (
    .clk_i, .rst_ni, .flush_i(busy_q), .room_i(!rx_full), .valid_i(rx_valid_i),
    .byte_i(rx_byte_i), .ready_o(rx_ready_o), .push_o(rx_push), .word_o(rx_in_word));

  always_comb begin
    ev_set = '0;
    ev_set[SRC_RX_FULL]  = int'(rx_cnt) > int'(rx_thr_q);
    ev_set[SRC_RX_UNDER] = rx_unf;
    ev_set[SRC_TX_OVER]  = tx_ovf;
    ev_set[SRC_TX_EMPTY] = int'(tx_cnt) <= int'(tx_thr_q);
    ev_set[SRC_DONE]     = done_i;
    ev_set[SRC_BUS_ERR]  = bus_err_i;
    ev_set[SRC_PROTO]    = proto_err_i;
    ev_set[SRC_DMA]      = dma_done_i;
  end

  irq_regs #(.N(NUM_SRC)) u_irq (
    .clk_i, .rst_ni, .set_i(ev_set),
    .clr_we_i(reg_we_i && (sel == SEL_CLEAR)), .clr_i(reg_wdata_i[NUM_SRC-1:0]),
    .mask_we_i(reg_we_i && (sel == SEL_MASK)), .mask_i(reg_wdata_i[NUM_SRC-1:0]),
    .raw_o(raw), .mask_o(mask), .masked_o(masked), .irq_o(irq_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (reg_we_i && (sel == SEL_THRESH)) begin
      tx_thr_q <= reg_wdata_i[4:0];
      rx_thr_q <= reg_wdata_i[12:8];
    end
  end

  // soft reset: counts down RST_CYCLES cycles, then releases itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rc_cnt_q <= '0;
    end else if (busy_q) begin
      if (rc_cnt_q == '0) busy_q <= 1'b0;
      else                rc_cnt_q <= rc_cnt_q - 1'b1;
    end else if (reg_we_i && (sel == SEL_RECOVER) && reg_wdata_i[0]) begin
      busy_q   <= 1'b1;
      rc_cnt_q <= RC_W'(RST_CYCLES - 1);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_MASK:    reg_rdata_o[NUM_SRC-1:0] = mask;
      SEL_THRESH:  begin
        reg_rdata_o[4:0]  = tx_thr_q;
        reg_rdata_o[12:8] = rx_thr_q;
      end
      SEL_RECOVER: reg_rdata_o[0] = busy_q;
      SEL_MSTAT:   reg_rdata_o[NUM_SRC-1:0] = masked;
      SEL_FSTAT:   begin
        reg_rdata_o[0]     = tx_full;
        reg_rdata_o[1]     = tx_empty;
        reg_rdata_o[2]     = rx_empty;
        reg_rdata_o[3]     = rx_full;
        reg_rdata_o[13:8]  = 6'(tx_free);
        reg_rdata_o[20:16] = 5'(rx_cnt);
      end
      SEL_RSTAT:   reg_rdata_o[NUM_SRC-1:0] = raw;
      SEL_DATA:    reg_rdata_o = rx_empty ? '0 : rx_word;
      default:     reg_rdata_o = '0;
    endcase
  end

  assert_ovf_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && tx_full) |=> raw[SRC_TX_OVER]);
  assert_unf_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && rx_empty) |-> (reg_rdata_o == '0));
  assert_recover_starts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (sel == SEL_RECOVER) && reg_wdata_i[0]) |=> eng_flush_o);
  assert_flush_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eng_flush_o) |-> (tx_empty && rx_empty));
  assert_tx_quiet_in_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_flush_o |-> !tx_valid_o);
endmodule

// File: tb/sim_fifo_irq_unit.sv
module sim_fifo_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int RST_CYCLES = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic [7:0] tx_byte, rx_byte = '0;
  logic done = 1'b0, bus_err = 1'b0, proto_err = 1'b0, dma_done = 1'b0;
  logic eng_flush, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_irq_unit #(.DEPTH(DEPTH), .RST_CYCLES(RST_CYCLES)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .rx_ready_o(rx_ready),
    .done_i(done), .bus_err_i(bus_err), .proto_err_i(proto_err), .dma_done_i(dma_done),
    .eng_flush_o(eng_flush), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_idx = idx;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, output logic took);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    #1 took = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic soft_reset();
    reg_wr(3'd3, 32'h1);
    repeat (RST_CYCLES + 2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    reg_rd(3'd0, d); chk("R1 mask reset", d, 32'hFF);
    reg_rd(3'd5, d); chk("R5 fifo status reset", d, 32'h0000_1006);
    reg_rd(3'd4, d); chk("R1 masked reset", d, 32'h0);
    reg_rd(3'd3, d); chk("R11 recovery idle", d, 32'h0);
    chk("R4 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_tx_path();
    logic [31:0] d;
    logic [7:0] got [8];
    int n = 0;
    reg_wr(3'd7, 32'h4433_2211);
    reg_wr(3'd7, 32'h8877_6655);
    reg_rd(3'd5, d); chk("R5 tx free after two", d, 32'h0000_0E04);
    @(negedge clk);
    tx_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #1;
      if (tx_valid && n < 8) begin got[n] = tx_byte; n++; end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R6 tx byte count", n, 8);
    chk("R6 tx bytes word0", {got[3], got[2], got[1], got[0]}, 32'h4433_2211);
    chk("R6 tx bytes word1", {got[7], got[6], got[5], got[4]}, 32'h8877_6655);
  endtask

  task automatic t_tx_overflow();
    logic [31:0] d;
    int n = 0;
    logic [7:0] last [4];
    reg_wr(3'd1, 32'hFF);
    reg_rd(3'd6, d); chk("R3 clear all", d & 32'h07, 32'h0);
    for (int i = 0; i < DEPTH; i++) reg_wr(3'd7, 32'h1000_0000 + i);
    reg_rd(3'd6, d); chk("R8 no overflow at capacity", d & 32'h4, 32'h0);
    reg_wr(3'd7, 32'hDEAD_BEEF);
    reg_rd(3'd5, d); chk("R5 tx full status", d, 32'h0000_0005);
    reg_rd(3'd6, d); chk("R8 overflow flag", d & 32'h4, 32'h4);
    reg_wr(3'd1, 32'h04);
    reg_rd(3'd6, d); chk("R3 clear bit2 only", d & 32'h4, 32'h0);
    @(negedge clk);
    tx_ready = 1'b1;
    for (int i = 0; i < 80; i++) begin
      #1;
      if (tx_valid) begin last[n % 4] = tx_byte; n++; end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R8 dropped write not sent", n, 64);
    chk("R8 last word kept", {last[3], last[2], last[1], last[0]}, 32'h1000_000F);
  endtask

  task automatic t_rx_path();
    logic [31:0] d;
    logic took;
    for (int i = 0; i < 8; i++) rx_send(8'hA1 + 8'(i), took);
    reg_rd(3'd5, d); chk("R5 rx level two", d, 32'h0002_1002);
    reg_rd(3'd7, d); chk("R7 rx word0", d, 32'hA4A3_A2A1);
    reg_rd(3'd7, d); chk("R7 rx word1", d, 32'hA8A7_A6A5);
    reg_wr(3'd1, 32'hFF);
    reg_rd(3'd7, d); chk("R9 underflow data zero", d, 32'h0);
    reg_rd(3'd6, d); chk("R9 underflow flag", d & 32'h2, 32'h2);
  endtask

  task automatic t_rx_backpressure();
    logic [31:0] d;
    logic took;
    int acc = 0;
    for (int i = 0; i < 4*DEPTH + 3; i++) begin
      rx_send(8'(i), took);
      if (took) acc++;
    end
    chk("R7 all bytes taken until full", acc, 4*DEPTH + 3);
    reg_rd(3'd5, d); chk("R5 rx full status", d, 32'h0010_100A);
    rx_send(8'h55, took);
    chk("R7 fourth byte refused", {31'b0, took}, 32'h0);
    reg_rd(3'd7, d); chk("R7 first packed word", d, 32'h0302_0100);
    @(negedge clk);
    #1 chk("R7 ready after pop", {31'b0, rx_ready}, 32'h1);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    reg_wr(3'd7, 32'h1);
    reg_wr(3'd3, 32'h1);
    reg_rd(3'd3, d); chk("R11 busy reads one", d, 32'h1);
    chk("R11 engine flush high", {31'b0, eng_flush}, 32'h1);
    repeat (RST_CYCLES + 2) @(negedge clk);
    reg_rd(3'd3, d); chk("R11 self cleared", d, 32'h0);
    reg_rd(3'd5, d); chk("R11 fifos emptied", d, 32'h0000_1006);
  endtask

  task automatic t_events_mask();
    logic [31:0] d;
    reg_wr(3'd0, 32'hFF);
    reg_wr(3'd1, 32'hFF);
    reg_wr(3'd2, 32'h0000_0100); // keep level sources quiet apart from tx empty
    reg_wr(3'd1, 32'hFF);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    reg_rd(3'd6, d); chk("R2 masked event recorded", d & 32'hF0, 32'h10);
    reg_rd(3'd4, d); chk("R1 masked view hidden", d, 32'h0);
    chk("R4 irq low while masked", {31'b0, irq}, 32'h0);
    reg_wr(3'd0, 32'hEF);
    chk("R4 irq one cycle late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R4 irq asserted", {31'b0, irq}, 32'h1);
    reg_rd(3'd4, d); chk("R1 masked shows bit4", d, 32'h10);
    reg_wr(3'd1, 32'h10);
    @(negedge clk);
    chk("R3 irq drops after clear", {31'b0, irq}, 32'h0);
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0; proto_err = 1'b1;
    @(negedge clk); proto_err = 1'b0; dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    reg_rd(3'd6, d); chk("R12 event bit positions", d & 32'hF0, 32'hE0);
    reg_wr(3'd0, 32'hFF);
  endtask

  task automatic t_thresholds();
    logic [31:0] d;
    logic took;
    reg_wr(3'd2, 32'h0000_0102);
    reg_rd(3'd2, d); chk("R10 threshold readback", d, 32'h0000_0102);
    reg_wr(3'd1, 32'hFF);
    reg_rd(3'd6, d); chk("R3 level source re-sets", d & 32'h8, 32'h8);
    for (int i = 0; i < 4; i++) rx_send(8'(i), took);
    reg_wr(3'd1, 32'hFF);
    reg_rd(3'd6, d); chk("R10 rx one word at thr1", d & 32'h1, 32'h0);
    for (int i = 0; i < 4; i++) rx_send(8'(i), took);
    reg_rd(3'd6, d); chk("R10 rx two words above thr1", d & 32'h1, 32'h1);
    for (int i = 0; i < 3; i++) reg_wr(3'd7, 32'(i));
    reg_wr(3'd1, 32'hFF);
    @(negedge clk);
    reg_rd(3'd6, d); chk("R10 tx three words above thr2", d & 32'h8, 32'h0);
    soft_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_tx_path();
    t_tx_overflow();
    t_rx_path();
    t_rx_backpressure();
    t_soft_reset();
    t_events_mask();
    t_thresholds();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule